// File: doc/BRIEF.md
# Framed Line AIS Detector

This block monitors a received serial line, one bit per clock on which a valid strobe is high, and decides whether the far end is sending an alarm indication signal. An alarm indication signal is a nearly all-ones stream. The block counts zeros over fixed, back-to-back measurement windows. At the close of each window it combines the zero count with a frame-alignment-lost flag from an external framer, and uses the result to set or clear a single status output.

A mode input selects between the 2.048 Mb/s (E1) rule set and the 1.544 Mb/s (T1) rule set. In E1 mode a window is 512 bits long, and the decision needs two consecutive windows that agree. A small state machine holds the verdict of the previous window for that purpose. In T1 mode a window is 4632 bits long, and one window is enough. The flag clears at once when frame alignment is reported as recovered. The flag, the window counters and the window history all restart when the mode changes.

The state machine has four states. CLEAR means no alarm and no history. ARM_SET means no alarm yet, and the previous E1 window was low in zeros. ALARM means the alarm is raised. ARM_CLR means the alarm is raised, and the previous E1 window was rich in zeros. The transitions are as follows:

- CLEAR goes to ARM_SET on an E1 low window, or to ALARM on a T1 low window while alignment is lost.
- ARM_SET goes to ALARM on a low window while alignment is lost, stays in ARM_SET on a low window while alignment is held, and goes to CLEAR on a rich window.
- ALARM goes to ARM_CLR on an E1 rich window, or to CLEAR on a T1 rich window.
- ARM_CLR goes to CLEAR on a rich window, and back to ALARM on a low window.
- ALARM and ARM_CLR both go to CLEAR on any valid bit that arrives while alignment is held.
- Any state goes to CLEAR on a mode change.

Top module: `ais_line_monitor`

## Requirements
- R1: During and right after reset `ais_alarm` is 0. The window counters and the window history are empty, and the mode reference is E1 (`mode_t1` = 0).
- R2: Only cycles with `bit_vld` = 1 are counted. `bit_in` = 0 counts as a zero. Windows follow one another with no gap or overlap, and the count of zeros starts from nothing at each window.
- R3: With `mode_t1` = 0, windows are 512 valid bits long. The flag rises when two consecutive windows each hold 2 or fewer zeros and `align_lost` = 1 on the closing bit of the second window. A window with 3 or more zeros between two low windows breaks the pair.
- R4: With `mode_t1` = 0 and the flag set, the flag falls when two consecutive windows each hold 3 or more zeros. A low window between two rich windows breaks the pair.
- R5: With `mode_t1` = 1, windows are 4632 valid bits long. The flag rises when one window holds 4 or fewer zeros and `align_lost` = 1 on its closing bit.
- R6: With `mode_t1` = 1, the flag falls when one window holds 5 or more zeros.
- R7: While the flag is set, a valid bit that arrives with `align_lost` = 0 clears the flag at that clock edge. Any E1 history is dropped at the same time.
- R8: Apart from R7 and R9, `ais_alarm` changes only at the clock edge that takes the closing bit of a window.
- R9: On any clock where `mode_t1` differs from its value on the previous clock, the flag, the counters and the history are cleared, and the bit offered on that clock is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | Marks the cycle as carrying a line bit |
| bit_in | input | 1 | Received line bit |
| mode_t1 | input | 1 | 0 = E1 rules, 1 = T1 rules |
| align_lost | input | 1 | Frame alignment lost, from the framer |
| ais_alarm | output | 1 | Alarm indication signal detected |

## Verification
The bench goes after the E1 pairing rules. It places a single rich window between two low windows, and a single low window between two rich windows. A design that keeps a count of low windows, instead of requiring them to be consecutive, would raise or drop the flag one window too early. The bench also inserts idle cycles that carry zeros, which would make a design that counts unqualified bits see rich windows and never alarm. It recovers alignment partway through a window, then checks that the following windows stay on the original 512-bit grid. It switches modes to confirm that E1 history left over from before the switch cannot complete a pair. In T1 mode it checks that the flag holds through 4631 zero-rich bits and falls only on the closing bit, which exposes a design that decides before the window ends.

// File: rtl/ais_det_pkg.sv
package ais_det_pkg;

    // Alarm state machine encoding
    typedef enum logic [1:0] {
        ST_CLEAR   = 2'd0,   // no alarm, no window history
        ST_ARM_SET = 2'd1,   // no alarm, previous E1 window was low in zeros
        ST_ALARM   = 2'd2,   // alarm raised
        ST_ARM_CLR = 2'd3    // alarm raised, previous E1 window was zero-rich
    } ais_state_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ais_window_counter.sv
module ais_window_counter
    import ais_det_pkg::*;
#(
    parameter int E1_WIN_BITS = 512,
    parameter int T1_WIN_BITS = 4632,
    localparam int MAXW = max_int(E1_WIN_BITS, T1_WIN_BITS),
    localparam int CW   = $clog2(MAXW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          mode_t1,
    input  logic          bit_vld,
    input  logic          bit_in,
    output logic          win_end,
    output logic [CW-1:0] win_zeros
);

    logic [CW-1:0] bit_cnt;
    logic [CW-1:0] zero_cnt;
    logic [CW-1:0] last_idx;

    assign last_idx  = mode_t1 ? CW'(T1_WIN_BITS - 1) : CW'(E1_WIN_BITS - 1);
    assign win_end   = bit_vld && !restart && (bit_cnt == last_idx);
    assign win_zeros = zero_cnt + CW'(!bit_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            zero_cnt <= '0;
        end else if (restart) begin
            bit_cnt  <= '0;
            zero_cnt <= '0;
        end else if (bit_vld) begin
            if (bit_cnt == last_idx) begin
                bit_cnt  <= '0;
                zero_cnt <= '0;
            end else begin
                bit_cnt  <= bit_cnt + 1'b1;
                zero_cnt <= zero_cnt + CW'(!bit_in);
            end
        end
    end

    // R2: position never runs past the window end
    a_r2_pos_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= last_idx);

    // R2: zeros counted never exceed bits counted in the window
    a_r2_zeros_le_bits: assert property (@(posedge clk) disable iff (!rst_n)
        zero_cnt <= bit_cnt);

    // R2: a bit-less cycle leaves the window position untouched
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld && !restart) |=> $stable(bit_cnt));

endmodule

// File: rtl/ais_window_judge.sv
module ais_window_judge #(
    parameter int CW         = 13,
    parameter int E1_LOW_MAX = 2,
    parameter int T1_LOW_MAX = 4
) (
    input  logic          mode_t1,
    input  logic [CW-1:0] win_zeros,
    output logic          win_low
);

    logic [CW-1:0] limit;

    assign limit   = mode_t1 ? CW'(T1_LOW_MAX) : CW'(E1_LOW_MAX);
    assign win_low = (win_zeros <= limit);

endmodule

// File: rtl/ais_alarm_fsm.sv
module ais_alarm_fsm
    import ais_det_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic mode_t1,
    input  logic bit_vld,
    input  logic win_end,
    input  logic win_low,
    input  logic align_lost,
    output logic ais
);

    ais_state_t state;
    ais_state_t nxt;
    logic       recov;

    assign recov = bit_vld && !align_lost;

    always_comb begin
        nxt = state;
        if (restart) begin
            nxt = ST_CLEAR;
        end else begin
            unique case (state)
                ST_CLEAR: begin
                    if (win_end && win_low) begin
                        if (mode_t1) nxt = align_lost ? ST_ALARM : ST_CLEAR;
                        else         nxt = ST_ARM_SET;
                    end
                end
                ST_ARM_SET: begin
                    if (win_end) begin
                        if (!win_low)        nxt = ST_CLEAR;
                        else if (align_lost) nxt = ST_ALARM;
                        else                 nxt = ST_ARM_SET;
                    end
                end
                ST_ALARM: begin
                    if (recov)                    nxt = ST_CLEAR;
                    else if (win_end && !win_low) nxt = mode_t1 ? ST_CLEAR : ST_ARM_CLR;
                end
                ST_ARM_CLR: begin
                    if (recov)        nxt = ST_CLEAR;
                    else if (win_end) nxt = win_low ? ST_ALARM : ST_CLEAR;
                end
                default: nxt = ST_CLEAR;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CLEAR;
        else        state <= nxt;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ais <= 1'b0;
        else        ais <= (nxt == ST_ALARM) || (nxt == ST_ARM_CLR);
    end

    // R3 R5 R8: a rise only follows a low window closing with alignment lost
    a_r8_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ais) |-> $past(win_end && win_low && align_lost));

    // R4 R6 R7 R8: a fall has a cause in the cycle before
    a_r7_fall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ais) |-> $past(restart || (bit_vld && !align_lost) || (win_end && !win_low)));

    // R9: a mode change leaves the flag low
    a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !ais);

    // R3: the one-window history states exist only under E1 rules
    a_r3_history_e1_only: assert property (@(posedge clk) disable iff (!rst_n)
        (((state == ST_ARM_SET) || (state == ST_ARM_CLR)) && !restart) |-> !mode_t1);

endmodule

// File: rtl/ais_line_monitor.sv
module ais_line_monitor
    import ais_det_pkg::*;
#(
    parameter int E1_WIN_BITS = 512,
    parameter int T1_WIN_BITS = 4632,
    parameter int E1_LOW_MAX  = 2,
    parameter int T1_LOW_MAX  = 4,
    localparam int MAXW = max_int(E1_WIN_BITS, T1_WIN_BITS),
    localparam int CW   = $clog2(MAXW + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    input  logic mode_t1,
    input  logic align_lost,
    output logic ais_alarm
);

    logic          mode_q;
    logic          restart;
    logic          win_end;
    logic          win_low;
    logic [CW-1:0] win_zeros;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= mode_t1;
    end

    assign restart = (mode_t1 != mode_q);

    ais_window_counter #(
        .E1_WIN_BITS (E1_WIN_BITS),
        .T1_WIN_BITS (T1_WIN_BITS)
    ) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .mode_t1   (mode_t1),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .win_end   (win_end),
        .win_zeros (win_zeros)
    );

    ais_window_judge #(
        .CW         (CW),
        .E1_LOW_MAX (E1_LOW_MAX),
        .T1_LOW_MAX (T1_LOW_MAX)
    ) i_judge (
        .mode_t1   (mode_t1),
        .win_zeros (win_zeros),
        .win_low   (win_low)
    );

    ais_alarm_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .mode_t1    (mode_t1),
        .bit_vld    (bit_vld),
        .win_end    (win_end),
        .win_low    (win_low),
        .align_lost (align_lost),
        .ais        (ais_alarm)
    );

    // R1: after reset the flag is low until a window has closed
    a_r1_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !ais_alarm);

endmodule

// File: tb/test_ais_line_monitor.sv
module test_ais_line_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int E1_LEN = 512;
    localparam int T1_LEN = 4632;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld = 1'b0;
    logic bit_in = 1'b1;
    logic mode_t1 = 1'b0;
    logic align_lost = 1'b1;
    logic ais_alarm;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ais_line_monitor i_ais_line_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_vld    (bit_vld),
        .bit_in     (bit_in),
        .mode_t1    (mode_t1),
        .align_lost (align_lost),
        .ais_alarm  (ais_alarm)
    );

    // Behavioural reference: position, zeros, last window verdict (0 none, 1 low, 2 rich)
    int m_pos = 0;
    int m_zero = 0;
    int m_prev = 0;
    bit m_flag = 1'b0;
    bit m_mode = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_zero = 0; m_prev = 0; m_flag = 1'b0; m_mode = 1'b0;
        end else if (mode_t1 != m_mode) begin
            m_mode = mode_t1; m_pos = 0; m_zero = 0; m_prev = 0; m_flag = 1'b0;
        end else if (bit_vld) begin
            int len;
            bit closing;
            bit low;
            len = m_mode ? T1_LEN : E1_LEN;
            if (!bit_in) m_zero++;
            m_pos++;
            closing = (m_pos == len);
            low = (m_zero <= (m_mode ? 4 : 2));
            if (m_flag && !align_lost) begin
                m_flag = 1'b0; m_prev = 0;
            end else if (closing) begin
                if (m_mode) begin
                    if (low && align_lost) m_flag = 1'b1;
                    else if (!low)         m_flag = 1'b0;
                end else if (!m_flag) begin
                    if (low && m_prev == 1 && align_lost) begin m_flag = 1'b1; m_prev = 0; end
                    else m_prev = low ? 1 : 0;
                end else begin
                    if (!low && m_prev == 2) begin m_flag = 1'b0; m_prev = 0; end
                    else m_prev = low ? 0 : 2;
                end
            end
            if (closing) begin m_pos = 0; m_zero = 0; end
        end
    end

    // R8: every cycle the output must follow the reference
    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (ais_alarm !== m_flag) begin
                fails++;
                $display("FAIL R8 cycle %0d: ais_alarm=%b expected %b", cycles, ais_alarm, m_flag);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected under 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic exp);
        vectors++;
        if (ais_alarm !== exp) begin
            fails++;
            $display("FAIL %s: ais_alarm=%b expected %b", tag, ais_alarm, exp);
        end
    endtask

    // count valid bits, the first nz are zeros; gap inserts idle zero cycles
    task automatic send_bits(input int count, input int nz, input logic lost, input bit gap);
        for (int i = 0; i < count; i++) begin
            if (gap && (i % 7 == 0)) begin
                @(negedge clk);
                bit_vld = 1'b0; bit_in = 1'b0;
            end
            @(negedge clk);
            bit_vld = 1'b1;
            bit_in = (i < nz) ? 1'b0 : 1'b1;
            align_lost = lost;
        end
        @(negedge clk);
        bit_vld = 1'b0; bit_in = 1'b1;
    endtask

    task automatic switch_mode(input logic m);
        @(negedge clk);
        mode_t1 = m; bit_vld = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check("R1 in reset", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 1'b0);

        // E1 set and clear pairing
        send_bits(E1_LEN, 0, 1'b1, 1'b0);   check("R3 one low window", 1'b0);
        send_bits(E1_LEN, 2, 1'b1, 1'b0);   check("R3 second low window sets", 1'b1);
        send_bits(E1_LEN, 3, 1'b1, 1'b0);   check("R4 one rich window holds", 1'b1);
        send_bits(E1_LEN, 200, 1'b1, 1'b0); check("R4 second rich window clears", 1'b0);
        send_bits(E1_LEN, 1, 1'b1, 1'b0);   check("R3 low", 1'b0);
        send_bits(E1_LEN, 3, 1'b1, 1'b0);   check("R3 rich breaks pair", 1'b0);
        send_bits(E1_LEN, 2, 1'b1, 1'b0);   check("R3 low after break", 1'b0);
        send_bits(E1_LEN, 0, 1'b1, 1'b0);   check("R3 fresh pair sets", 1'b1);
        send_bits(E1_LEN, 3, 1'b1, 1'b0);   check("R4 rich", 1'b1);
        send_bits(E1_LEN, 0, 1'b1, 1'b0);   check("R4 low breaks pair", 1'b1);
        send_bits(E1_LEN, 9, 1'b1, 1'b0);   check("R4 rich after break", 1'b1);
        send_bits(E1_LEN, 9, 1'b1, 1'b0);   check("R4 fresh pair clears", 1'b0);

        // idle cycles carry zeros that must not count
        send_bits(E1_LEN, 2, 1'b1, 1'b1);   check("R2 gapped low", 1'b0);
        send_bits(E1_LEN, 0, 1'b1, 1'b1);   check("R2 gapped pair sets", 1'b1);

        // recovery mid-window, then grid stays aligned
        send_bits(1, 0, 1'b0, 1'b0);        check("R7 recovery clears", 1'b0);
        send_bits(E1_LEN - 1, 0, 1'b1, 1'b0); check("R2 window after recovery", 1'b0);
        send_bits(E1_LEN, 0, 1'b1, 1'b0);   check("R2 grid kept, pair sets", 1'b1);

        // E1 low pair with alignment held does not set
        switch_mode(1'b1); switch_mode(1'b0);
        check("R9 mode change clears", 1'b0);
        send_bits(E1_LEN, 0, 1'b0, 1'b0);
        send_bits(E1_LEN, 0, 1'b0, 1'b0);   check("R3 aligned pair no set", 1'b0);

        // T1 rules
        switch_mode(1'b1);
        check("R9 into T1", 1'b0);
        send_bits(T1_LEN, 4, 1'b1, 1'b0);   check("R5 four zeros sets", 1'b1);
        send_bits(T1_LEN, 5, 1'b1, 1'b0);   check("R6 five zeros clears", 1'b0);
        send_bits(T1_LEN, 4, 1'b0, 1'b0);   check("R5 aligned no set", 1'b0);
        send_bits(T1_LEN, 0, 1'b1, 1'b0);   check("R5 sets again", 1'b1);
        send_bits(T1_LEN - 1, 10, 1'b1, 1'b0); check("R8 holds mid window", 1'b1);
        send_bits(1, 0, 1'b1, 1'b0);        check("R6 clears on closing bit", 1'b0);

        // history dropped across mode change
        switch_mode(1'b0);
        send_bits(E1_LEN, 0, 1'b1, 1'b0);   check("R3 armed", 1'b0);
        switch_mode(1'b1); switch_mode(1'b0);
        send_bits(E1_LEN, 0, 1'b1, 1'b0);   check("R9 history cleared", 1'b0);
        send_bits(E1_LEN, 0, 1'b1, 1'b0);   check("R9 new pair sets", 1'b1);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule